// File: doc/BRIEF.md
# Pad Delay Configuration Register Bank

This block is the 32-bit memory-mapped register file of a pad delay controller. It holds one small configuration word per pad. Each word gives the number of coarse and fine delay elements to switch into that pad's delay line, plus a sticky per-pad lock bit. It also holds three read-only calibration registers, which are filled from side inputs, and a global key register that guards the whole pad region.

Software first writes the unlock key to the key register. It then writes each pad word. A pad word commits only if three conditions hold: the region is unlocked, the pad's own lock bit is still clear, and the written word carries the fixed 6-bit signature. A write that is refused, and any access above the top of the map, returns a single-cycle error pulse. Reads return registered data one cycle after the request.

Top module: `padcfg_regbank`

## Requirements
- R1: After reset the region is locked, so a read of offset 0x2C returns 0x0000AAAB. Every pad word reads as lock 0, coarse 0 and fine 0, with the signature field still present.
- R2: A write to offset 0x2C compares only bits 15:0 of the written word. The value 0xAAAA unlocks the region and the value 0xAAAB locks it. Any other value leaves the lock state unchanged. A read of 0x2C returns 0xAAAA while unlocked and 0xAAAB while locked.
- R3: Calibration values are captured from the side inputs in the cycle that cal_load_i is high. Offset 0x14 reads the reference period in bits 15:0. Offset 0x18 reads the coarse delay count in bits 31:16 and the coarse reference count in bits 15:0. Offset 0x1C reads the fine counts with the same layout.
- R4: Bus writes to 0x14, 0x18 and 0x1C change nothing and raise no error.
- R5: Pad registers sit at offsets 0x30 + 4*n for n from 0 to 826, so the last pad is at 0xD18. A write is accepted when all of the following hold: the region is unlocked, the pad's lock bit is clear, and bits 17:12 of the word equal 0x29. An accepted write stores bit 10 as the lock bit, bits 9:5 as the coarse elements and bits 4:0 as the fine elements, and raises no error.
- R6: A pad write while the region is locked is ignored, and err_o pulses in the following cycle.
- R7: A pad write whose bits 17:12 differ from 0x29 is ignored, and err_o pulses.
- R8: Once a pad's lock bit is 1, further writes to that pad are ignored and pulse err_o, until reset.
- R9: A pad read returns 0x29 in bits 17:12. It returns the stored lock bit, coarse field and fine field in bits 10, 9:5 and 4:0. Bits 31:18 and bit 11 read as zero.
- R10: Any access above 0xD1C pulses err_o, and a read there returns zero. Unmapped offsets at or below 0xD1C, such as 0x00 and 0xD1C, read as zero, ignore writes and raise no error.
- R11: rvalid_o is high for exactly the one cycle after each read request and never after a write. err_o is a one-cycle pulse aligned with that same response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| err_o | output | 1 | One-cycle error pulse for a refused or out-of-range access |
| cal_load_i | input | 1 | Capture strobe for calibration values |
| cal_period_i | input | 16 | Reference clock period |
| cal_coarse_dly_i | input | 16 | Coarse delay count |
| cal_coarse_ref_i | input | 16 | Coarse reference count |
| cal_fine_dly_i | input | 16 | Fine delay count |
| cal_fine_ref_i | input | 16 | Fine reference count |

## Verification
The embedded assertions check a set of rules on every cycle:
- the response timing of rvalid_o;
- zero data and an error on out-of-range reads;
- the constant signature on every pad read;
- an error on every pad write made while the region is locked;
- the key register holding its state against non-key values;
- the calibration words staying stable without a load strobe;
- the store never being written over a locked entry.

Some behaviours only the directed scenarios can show, because they depend on the stored pad contents. These are the field placement of an accepted write, the refusal of a wrong signature, the sticky per-pad lock, the last-pad boundary at 0xD18, and the silent no-effect writes to calibration offsets.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int unsigned KEY_OFFS    = 32'h2C;
  localparam int unsigned PERIOD_OFFS = 32'h14;
  localparam int unsigned COARSE_OFFS = 32'h18;
  localparam int unsigned FINE_OFFS   = 32'h1C;

  localparam logic [15:0] KEY_UNLOCK = 16'hAAAA;
  localparam logic [15:0] KEY_LOCK   = 16'hAAAB;

  localparam logic [5:0] PAD_SIG = 6'h29;
  localparam int unsigned SIG_LSB    = 12;
  localparam int unsigned LOCK_BIT   = 10;
  localparam int unsigned ELEM_W     = 5;
  localparam int unsigned COARSE_LSB = 5;
  localparam int unsigned FINE_LSB   = 0;

  typedef struct packed {
    logic              lock;
    logic [ELEM_W-1:0] coarse;
    logic [ELEM_W-1:0] fine;
  } pad_cfg_t;
endpackage

// File: rtl/padcfg_key_lock.sv
module padcfg_key_lock
  import padcfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic [15:0] key_i,
  output logic        locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             locked_q <= 1'b1;
    else if (key_wr_i && key_i == KEY_UNLOCK) locked_q <= 1'b0;
    else if (key_wr_i && key_i == KEY_LOCK)   locked_q <= 1'b1;
  end

  assign locked_o = locked_q;

  assert_bad_key_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i != KEY_UNLOCK && key_i != KEY_LOCK) |=> $stable(locked_o));
  assert_unlock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i == KEY_UNLOCK) |=> !locked_o);
  assert_lock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i == KEY_LOCK) |=> locked_o);
endmodule

// File: rtl/padcfg_cal_regs.sv
module padcfg_cal_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [CNT_W-1:0]   coarse_dly_i,
  input  logic [CNT_W-1:0]   coarse_ref_i,
  input  logic [CNT_W-1:0]   fine_dly_i,
  input  logic [CNT_W-1:0]   fine_ref_i,
  output logic [CNT_W-1:0]   period_o,
  output logic [2*CNT_W-1:0] coarse_word_o,
  output logic [2*CNT_W-1:0] fine_word_o
);
  logic [CNT_W-1:0]   period_q;
  logic [2*CNT_W-1:0] coarse_q, fine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      coarse_q <= '0;
      fine_q   <= '0;
    end else if (load_i) begin
      period_q <= period_i;
      coarse_q <= {coarse_dly_i, coarse_ref_i};
      fine_q   <= {fine_dly_i, fine_ref_i};
    end
  end

  assign period_o      = period_q;
  assign coarse_word_o = coarse_q;
  assign fine_word_o   = fine_q;

  assert_cal_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(period_o) && $stable(coarse_word_o) && $stable(fine_word_o)));
endmodule

// File: rtl/padcfg_pad_store.sv
module padcfg_pad_store
  import padcfg_pkg::*;
#(
  parameter int unsigned NUM_PADS = 827,
  localparam int unsigned IDX_W = $clog2(NUM_PADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  pad_cfg_t         cfg_i,
  output pad_cfg_t         cfg_o
);
  pad_cfg_t mem_q [NUM_PADS];
  logic     idx_ok;

  assign idx_ok = 32'(idx_i) < NUM_PADS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PADS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && idx_ok) begin
      mem_q[idx_i] <= cfg_i;
    end
  end

  always_comb begin
    cfg_o = '0;
    if (idx_ok) cfg_o = mem_q[idx_i];
  end

  // the decoder must never commit over a locked entry
  assert_locked_entry_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !cfg_o.lock);
endmodule

// File: rtl/padcfg_regbank.sv
module padcfg_regbank
  import padcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TOP_OFFS = 32'hD1C,
  parameter int unsigned PAD_BASE = 32'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  input  logic              cal_load_i,
  input  logic [15:0]       cal_period_i,
  input  logic [15:0]       cal_coarse_dly_i,
  input  logic [15:0]       cal_coarse_ref_i,
  input  logic [15:0]       cal_fine_dly_i,
  input  logic [15:0]       cal_fine_ref_i
);
  localparam int unsigned NUM_PADS = (TOP_OFFS - PAD_BASE) / 4;
  localparam int unsigned IDX_W    = $clog2(NUM_PADS);
  localparam int unsigned PAD_END  = PAD_BASE + 4 * NUM_PADS;

  logic              locked;
  logic [15:0]       cal_period;
  logic [31:0]       cal_coarse, cal_fine;
  logic [ADDR_W-1:0] pad_off;
  logic [IDX_W-1:0]  pad_idx;
  logic              is_pad, is_oor, is_key;
  logic              sig_ok, pad_wr_ok;
  pad_cfg_t          cur_cfg, new_cfg;
  logic [31:0]       rd_mux;
  logic [31:0]       rdata_q;
  logic              rvalid_q, err_q;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata_i[31:SIG_LSB+6], wdata_i[LOCK_BIT+1]};

  // address decode
  assign is_oor  = 32'(addr_i) > TOP_OFFS;
  assign is_pad  = 32'(addr_i) >= PAD_BASE && 32'(addr_i) < PAD_END;
  assign is_key  = 32'(addr_i) == KEY_OFFS;
  assign pad_off = addr_i - ADDR_W'(PAD_BASE);
  assign pad_idx = pad_off[IDX_W+1:2];

  assign sig_ok    = wdata_i[SIG_LSB +: 6] == PAD_SIG;
  assign pad_wr_ok = !locked && !cur_cfg.lock && sig_ok;

  assign new_cfg.lock   = wdata_i[LOCK_BIT];
  assign new_cfg.coarse = wdata_i[COARSE_LSB +: ELEM_W];
  assign new_cfg.fine   = wdata_i[FINE_LSB +: ELEM_W];

  padcfg_key_lock u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (req_i && we_i && is_key),
    .key_i    (wdata_i[15:0]),
    .locked_o (locked)
  );

  padcfg_cal_regs #(.CNT_W(16)) u_cal (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (cal_load_i),
    .period_i      (cal_period_i),
    .coarse_dly_i  (cal_coarse_dly_i),
    .coarse_ref_i  (cal_coarse_ref_i),
    .fine_dly_i    (cal_fine_dly_i),
    .fine_ref_i    (cal_fine_ref_i),
    .period_o      (cal_period),
    .coarse_word_o (cal_coarse),
    .fine_word_o   (cal_fine)
  );

  padcfg_pad_store #(.NUM_PADS(NUM_PADS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (pad_idx),
    .wr_en_i (req_i && we_i && is_pad && pad_wr_ok),
    .cfg_i   (new_cfg),
    .cfg_o   (cur_cfg)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    if (is_pad) begin
      rd_mux[SIG_LSB +: 6]          = PAD_SIG;
      rd_mux[LOCK_BIT]              = cur_cfg.lock;
      rd_mux[COARSE_LSB +: ELEM_W]  = cur_cfg.coarse;
      rd_mux[FINE_LSB +: ELEM_W]    = cur_cfg.fine;
    end else if (is_key) begin
      rd_mux[15:0] = locked ? KEY_LOCK : KEY_UNLOCK;
    end else if (32'(addr_i) == PERIOD_OFFS) begin
      rd_mux[15:0] = cal_period;
    end else if (32'(addr_i) == COARSE_OFFS) begin
      rd_mux = cal_coarse;
    end else if (32'(addr_i) == FINE_OFFS) begin
      rd_mux = cal_fine;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      err_q    <= req_i && (is_oor || (we_i && is_pad && !pad_wr_ok));
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

  assert_rvalid_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_no_rvalid_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && !we_i)) |=> !rvalid_o);
  assert_oor_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && 32'(addr_i) > TOP_OFFS) |=> (err_o && rdata_o == '0));
  assert_locked_pad_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_pad && locked) |=> err_o);
  assert_sig_readback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && is_pad) |=> (rdata_o[SIG_LSB +: 6] == PAD_SIG && rdata_o[31:18] == '0));
endmodule

// File: tb/padcfg_regbank_test.sv
module padcfg_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, err;
  logic        cal_load = 1'b0;
  logic [15:0] cal_period = '0, cal_cd = '0, cal_cr = '0, cal_fd = '0, cal_fr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] r_data;
  logic        r_err, r_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  padcfg_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err),
    .cal_load_i(cal_load), .cal_period_i(cal_period),
    .cal_coarse_dly_i(cal_cd), .cal_coarse_ref_i(cal_cr),
    .cal_fine_dly_i(cal_fd), .cal_fine_ref_i(cal_fr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    r_data = rdata; r_err = err; r_valid = rvalid;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset;
    access(1'b0, 16'h002C, '0);
    chk("R1 key reset", r_data, 32'h0000AAAB);
    access(1'b0, 16'h0030, '0);
    chk("R1 pad reset", r_data, 32'h00029000);
    chk("R1 no err", {31'b0, r_err}, 32'h0);
  endtask

  task automatic t_cal;
    @(negedge clk);
    cal_period = 16'h1234; cal_cd = 16'h00A5; cal_cr = 16'h0102;
    cal_fd = 16'h0033; cal_fr = 16'h0456; cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0; cal_period = 16'hFFFF;
    access(1'b0, 16'h0014, '0);
    chk("R3 period", r_data, 32'h00001234);
    access(1'b0, 16'h0018, '0);
    chk("R3 coarse", r_data, 32'h00A50102);
    access(1'b0, 16'h001C, '0);
    chk("R3 fine", r_data, 32'h00330456);
    access(1'b1, 16'h0018, 32'hFFFFFFFF);
    chk("R4 cal write no err", {31'b0, r_err}, 32'h0);
    access(1'b0, 16'h0018, '0);
    chk("R4 cal unchanged", r_data, 32'h00A50102);
  endtask

  task automatic t_locked_write;
    access(1'b1, 16'h0030, 32'h00029067);
    chk("R6 locked err", {31'b0, r_err}, 32'h1);
    chk("R11 no rvalid on write", {31'b0, r_valid}, 32'h0);
    access(1'b0, 16'h0030, '0);
    chk("R6 pad unchanged", r_data, 32'h00029000);
  endtask

  task automatic t_key;
    access(1'b1, 16'h002C, 32'h00001234);
    access(1'b0, 16'h002C, '0);
    chk("R2 bad key ignored", r_data, 32'h0000AAAB);
    access(1'b1, 16'h002C, 32'hFFFFAAAA);
    access(1'b0, 16'h002C, '0);
    chk("R2 unlock", r_data, 32'h0000AAAA);
  endtask

  task automatic t_pad_ok;
    access(1'b1, 16'h0034, 32'h000293F5);
    chk("R5 accept no err", {31'b0, r_err}, 32'h0);
    access(1'b0, 16'h0034, '0);
    chk("R5 fields", r_data, 32'h000293F5);
    chk("R11 rvalid", {31'b0, r_valid}, 32'h1);
    access(1'b1, 16'h0038, 32'hFFFE9841);
    access(1'b0, 16'h0038, '0);
    chk("R9 spare bits zero", r_data, 32'h00029041);
    access(1'b1, 16'h0D18, 32'h00029022);
    access(1'b0, 16'h0D18, '0);
    chk("R5 last pad", r_data, 32'h00029022);
  endtask

  task automatic t_sig;
    access(1'b1, 16'h003C, 32'h00028025);
    chk("R7 bad sig err", {31'b0, r_err}, 32'h1);
    access(1'b0, 16'h003C, '0);
    chk("R7 pad unchanged", r_data, 32'h00029000);
  endtask

  task automatic t_padlock;
    access(1'b1, 16'h0040, 32'h000294A9);
    chk("R8 lock write ok", {31'b0, r_err}, 32'h0);
    access(1'b1, 16'h0040, 32'h00029011);
    chk("R8 locked pad err", {31'b0, r_err}, 32'h1);
    access(1'b0, 16'h0040, '0);
    chk("R8 locked pad kept", r_data, 32'h000294A9);
  endtask

  task automatic t_range;
    access(1'b0, 16'h0D20, '0);
    chk("R10 oor data", r_data, 32'h0);
    chk("R10 oor err", {31'b0, r_err}, 32'h1);
    @(posedge clk); #1;
    chk("R11 err one cycle", {31'b0, err}, 32'h0);
    chk("R11 rvalid one cycle", {31'b0, rvalid}, 32'h0);
    access(1'b0, 16'h0D1C, '0);
    chk("R10 unmapped data", r_data, 32'h0);
    chk("R10 unmapped no err", {31'b0, r_err}, 32'h0);
    access(1'b1, 16'h0D20, 32'h00029001);
    chk("R10 oor write err", {31'b0, r_err}, 32'h1);
    access(1'b1, 16'h0000, 32'h00029001);
    chk("R10 low unmapped no err", {31'b0, r_err}, 32'h0);
    access(1'b0, 16'h0000, '0);
    chk("R10 low unmapped data", r_data, 32'h0);
  endtask

  task automatic t_relock;
    access(1'b1, 16'h002C, 32'h0000AAAB);
    access(1'b0, 16'h002C, '0);
    chk("R2 relock", r_data, 32'h0000AAAB);
    access(1'b1, 16'h0044, 32'h00029003);
    chk("R6 relocked err", {31'b0, r_err}, 32'h1);
    access(1'b0, 16'h0044, '0);
    chk("R6 relocked unchanged", r_data, 32'h00029000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cal();
    t_locked_write();
    t_key();
    t_pad_ok();
    t_sig();
    t_padlock();
    t_range();
    t_relock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule